// File: doc/BRIEF.md
# Masked Bit-Field Register Writer

This unit updates a narrow field, one to eight bits wide, inside a byte-organised register file. The field is placed by a bit address. It may start at any bit of a byte, so it can run on into the following byte. A requester supplies the bit address, a pattern and a mask. The unit then reads the one or two bytes involved through a plain synchronous memory port and merges the new field into them. It writes the result back to the same locations and pulses `done`. The bits of the register file outside the mask are not changed.

The memory port returns read data one clock after the read strobe. The unit issues at most one read or one write per clock. It accepts a new request only while idle. A request presented while it is busy is dropped. When the field begins in the last byte of the file, there is no following byte. The unit then touches only that byte and discards the field bits that would lie beyond it.

Top module: `bitfield_rmw`

## Requirements
- R1: The bit address is split into a byte index (address divided by 8) and a shift (address modulo 8). The first read after acceptance targets the byte index.
- R2: For a field whose byte index is not the last byte, the access order is read index, read index+1, one merge cycle, write index, write index+1. `done` is high in the sixth cycle after the accepting clock edge.
- R3: The two bytes form a 16-bit word with the byte at the lower address as bits 7:0. The written word is (old AND NOT (mask << shift)) OR ((pattern AND mask) << shift).
- R4: Pattern bits outside the mask never reach memory. A pattern of 0xFF under mask 0x07 alters only three bits.
- R5: A field that crosses a byte boundary is written correctly. Writing 63 under mask 0x3F at bit address 462 turns bytes 57 and 58 from 0x00, 0x00 into 0xC0, 0x0F. Writing 0 there restores 0x00, 0x00.
- R6: When the byte index is the last byte (255), only that byte is read and written. Field bits above bit 7 are dropped, and `done` is high in the fourth cycle after acceptance.
- R7: A request raised while `busy` is high is ignored. It causes no memory access and does not change the register file.
- R8: The port never reads and writes in the same cycle. After reset, `busy`, `done` and both strobes are low. `done` lasts one cycle.
- R9: Contiguous masks of every width from 1 to 8 bits, at every shift, update exactly the masked bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request strobe, taken only while idle |
| bit_addr | input | 11 | Bit address of the field's least significant bit |
| pattern | input | 8 | New field value, right-aligned |
| mask | input | 8 | Field mask, right-aligned |
| busy | output | 1 | High from acceptance until `done` |
| done | output | 1 | One-cycle pulse after write-back |
| mem_addr | output | 8 | Byte address to the register file |
| mem_rd_en | output | 1 | Read strobe, data returns next cycle |
| mem_wr_en | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid one cycle after `mem_rd_en` |

## Verification
A wrong captured byte or a wrong merge shows up at the very next write strobe as a bad `mem_wdata`. That is two or three cycles after the read that fed it. The monitor compares each write the moment it appears. A stuck or skipping sequencer shows up as a wrong address on the first or second strobe, or as `done` arriving in the wrong cycle. The cycle of `done` is timed on every request. A lost top-of-file guard or request gate shows up as an extra access, or as a corrupted byte elsewhere in the file. A full sweep of the file after the run catches these.

// File: rtl/bfw_pkg.sv
package bfw_pkg;
  localparam int FIELD_W = 8;
  localparam int WORD_W  = 2 * FIELD_W;

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_RD_LO  = 3'd1,
    S_RD_HI  = 3'd2,
    S_MODIFY = 3'd3,
    S_WR_LO  = 3'd4,
    S_WR_HI  = 3'd5,
    S_DONE   = 3'd6
  } bfw_state_e;

  // Mask positioned inside the two-byte window.
  function automatic logic [WORD_W-1:0] place_field(input logic [FIELD_W-1:0] val,
                                                    input logic [2:0] sh);
    return {{FIELD_W{1'b0}}, val} << sh;
  endfunction

  // Read-modify-write merge of one field into the two-byte window.
  function automatic logic [WORD_W-1:0] merge_word(input logic [WORD_W-1:0]  old_word,
                                                   input logic [FIELD_W-1:0] pat,
                                                   input logic [FIELD_W-1:0] msk,
                                                   input logic [2:0]         sh);
    logic [WORD_W-1:0] keep;
    keep = ~place_field(msk, sh);
    return (old_word & keep) | place_field(pat & msk, sh);
  endfunction
endpackage

// File: rtl/bfw_addr_split.sv
module bfw_addr_split #(
  parameter int BYTES = 256,
  localparam int ADDR_W = $clog2(BYTES),
  localparam int BIT_ADDR_W = ADDR_W + 3
) (
  input  logic [BIT_ADDR_W-1:0] bit_addr,
  output logic [ADDR_W-1:0]     byte_idx,
  output logic [2:0]            shift,
  output logic                  at_top
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(BYTES - 1);

  always_comb begin
    byte_idx = bit_addr[BIT_ADDR_W-1:3];
    shift    = bit_addr[2:0];
    at_top   = (byte_idx == LAST);
  end
endmodule

// File: rtl/bfw_merge.sv
module bfw_merge
  import bfw_pkg::*;
(
  input  logic [FIELD_W-1:0] old_lo,
  input  logic [FIELD_W-1:0] old_hi,
  input  logic [FIELD_W-1:0] pat,
  input  logic [FIELD_W-1:0] msk,
  input  logic [2:0]         sh,
  input  logic               at_top,
  output logic [WORD_W-1:0]  new_word
);
  logic [WORD_W-1:0] old_word;
  logic [WORD_W-1:0] merged;

  always_comb begin
    old_word = {at_top ? {FIELD_W{1'b0}} : old_hi, old_lo};
    merged   = merge_word(old_word, pat, msk, sh);
    // upper half is never written at the top of the file
    new_word = at_top ? {{FIELD_W{1'b0}}, merged[FIELD_W-1:0]} : merged;
  end
endmodule

// File: rtl/bfw_seq.sv
module bfw_seq
  import bfw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       at_top,
  output bfw_state_e state,
  output logic       idle
);
  bfw_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      S_IDLE:   if (start) nxt = S_RD_LO;
      S_RD_LO:  nxt = at_top ? S_MODIFY : S_RD_HI;
      S_RD_HI:  nxt = S_MODIFY;
      S_MODIFY: nxt = S_WR_LO;
      S_WR_LO:  nxt = at_top ? S_DONE : S_WR_HI;
      S_WR_HI:  nxt = S_DONE;
      S_DONE:   nxt = S_IDLE;
      default:  nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= nxt;
  end

  assign idle = (state == S_IDLE);
endmodule

// File: rtl/bitfield_rmw.sv
module bitfield_rmw
  import bfw_pkg::*;
#(
  parameter int BYTES = 256,
  localparam int ADDR_W = $clog2(BYTES),
  localparam int BIT_ADDR_W = ADDR_W + 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req,
  input  logic [BIT_ADDR_W-1:0] bit_addr,
  input  logic [FIELD_W-1:0]    pattern,
  input  logic [FIELD_W-1:0]    mask,
  output logic                  busy,
  output logic                  done,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic                  mem_rd_en,
  output logic                  mem_wr_en,
  output logic [FIELD_W-1:0]    mem_wdata,
  input  logic [FIELD_W-1:0]    mem_rdata
);
  // decoded request
  logic [ADDR_W-1:0] dec_idx;
  logic [2:0]        dec_sh;
  logic              dec_top;

  // latched request
  logic [ADDR_W-1:0]  idx_q;
  logic [2:0]         sh_q;
  logic               top_q;
  logic [FIELD_W-1:0] pat_q;
  logic [FIELD_W-1:0] msk_q;
  logic [FIELD_W-1:0] lo_q;
  logic [WORD_W-1:0]  word_q;

  bfw_state_e state;
  logic       idle;

  // named internal events
  logic ev_accept, ev_cap_lo, ev_modify;
  logic [FIELD_W-1:0] old_lo, old_hi;
  logic [WORD_W-1:0]  new_word;
  logic [ADDR_W-1:0]  idx_next;

  bfw_addr_split #(.BYTES(BYTES)) u_split (
    .bit_addr (bit_addr),
    .byte_idx (dec_idx),
    .shift    (dec_sh),
    .at_top   (dec_top)
  );

  bfw_seq u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (ev_accept),
    .at_top (top_q),
    .state  (state),
    .idle   (idle)
  );

  assign ev_accept = req && idle;
  assign ev_cap_lo = (state == S_RD_HI);
  assign ev_modify = (state == S_MODIFY);
  assign idx_next  = idx_q + ADDR_W'(1);

  // In MODIFY the port shows the high byte, or the low byte when only one read ran.
  assign old_lo = top_q ? mem_rdata : lo_q;
  assign old_hi = top_q ? '0 : mem_rdata;

  bfw_merge u_merge (
    .old_lo   (old_lo),
    .old_hi   (old_hi),
    .pat      (pat_q),
    .msk      (msk_q),
    .sh       (sh_q),
    .at_top   (top_q),
    .new_word (new_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      sh_q   <= '0;
      top_q  <= 1'b0;
      pat_q  <= '0;
      msk_q  <= '0;
      lo_q   <= '0;
      word_q <= '0;
    end else begin
      if (ev_accept) begin
        idx_q <= dec_idx;
        sh_q  <= dec_sh;
        top_q <= dec_top;
        pat_q <= pattern;
        msk_q <= mask;
      end
      if (ev_cap_lo) lo_q   <= mem_rdata;
      if (ev_modify) word_q <= new_word;
    end
  end

  always_comb begin
    mem_addr  = idx_q;
    mem_rd_en = 1'b0;
    mem_wr_en = 1'b0;
    mem_wdata = '0;
    unique case (state)
      S_RD_LO: mem_rd_en = 1'b1;
      S_RD_HI: begin
        mem_rd_en = 1'b1;
        mem_addr  = idx_next;
      end
      S_WR_LO: begin
        mem_wr_en = 1'b1;
        mem_wdata = word_q[FIELD_W-1:0];
      end
      S_WR_HI: begin
        mem_wr_en = 1'b1;
        mem_addr  = idx_next;
        mem_wdata = word_q[WORD_W-1:FIELD_W];
      end
      default: ;
    endcase
  end

  assign busy = !idle;
  assign done = (state == S_DONE);
endmodule

// File: rtl/bitfield_rmw_chk.sv
module bitfield_rmw_chk #(
  parameter int BYTES = 256,
  localparam int ADDR_W = $clog2(BYTES),
  localparam int BIT_ADDR_W = ADDR_W + 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req,
  input logic [BIT_ADDR_W-1:0] bit_addr,
  input logic                  busy,
  input logic                  done,
  input logic [ADDR_W-1:0]     mem_addr,
  input logic                  mem_rd_en,
  input logic                  mem_wr_en
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(BYTES - 1);

  p_first_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !busy) |=> (mem_rd_en && mem_addr == $past(bit_addr[BIT_ADDR_W-1:3])));

  p_read_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && $past(mem_rd_en)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

  p_write_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && $past(mem_wr_en)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

  p_done_after_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_wr_en));

  p_top_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && mem_addr == LAST) |=> !mem_rd_en);

  p_top_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && mem_addr == LAST) |=> !mem_wr_en);

  p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  p_no_idle_access_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy) |-> (!mem_rd_en && !mem_wr_en));

  p_one_access_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind bitfield_rmw bitfield_rmw_chk #(.BYTES(BYTES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req       (req),
  .bit_addr  (bit_addr),
  .busy      (busy),
  .done      (done),
  .mem_addr  (mem_addr),
  .mem_rd_en (mem_rd_en),
  .mem_wr_en (mem_wr_en)
);

// File: tb/bitfield_rmw_bench.sv
module bitfield_rmw_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [10:0] bit_addr = '0;
  logic [7:0]  pattern = '0;
  logic [7:0]  mask = '0;
  logic        busy, done;
  logic [7:0]  mem_addr;
  logic        mem_rd_en, mem_wr_en;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;

  logic [7:0] mem    [256];
  logic [7:0] shadow [256];

  typedef struct {
    int    addr;
    int    data;
    string tag;
  } wr_item_t;
  wr_item_t exp_q[$];

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  bitfield_rmw u_bitfield_rmw (
    .clk(clk), .rst_n(rst_n), .req(req), .bit_addr(bit_addr),
    .pattern(pattern), .mask(mask), .busy(busy), .done(done),
    .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // register file model, one-cycle read latency
  always @(posedge clk) begin
    if (mem_wr_en) mem[mem_addr] <= mem_wdata;
    if (mem_rd_en) mem_rdata <= mem[mem_addr];
  end

  task automatic check(input bit ok, input string rq, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
    end
  endtask

  // monitor: pops expected writes as they appear on the port
  always @(negedge clk) begin
    if (rst_n && mem_wr_en) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7", "unexpected write addr", int'(mem_addr), -1);
      end else begin
        wr_item_t it;
        it = exp_q.pop_front();
        check(int'(mem_addr) == it.addr, it.tag, "write addr (R1)", int'(mem_addr), it.addr);
        check(int'(mem_wdata) == it.data, it.tag, "write data (R3)", int'(mem_wdata), it.data);
      end
    end
  end

  // driver: computes the expected result in its own terms and queues it
  task automatic do_write(input int ba, input logic [7:0] pat, input logic [7:0] msk,
                          input string tag, input bit inject);
    int idx, sh, cnt, want;
    logic [15:0] old, field_bits, keep_bits, nw;
    wr_item_t it;
    idx = ba / 8;
    sh  = ba % 8;
    old = {(idx == 255) ? 8'h00 : shadow[(idx + 1) % 256], shadow[idx]};
    field_bits = 16'(pat & msk) << sh;
    keep_bits  = ~(16'(msk) << sh);
    nw = (old & keep_bits) | field_bits;
    it.addr = idx; it.data = int'(nw[7:0]); it.tag = tag;
    exp_q.push_back(it);
    shadow[idx] = nw[7:0];
    if (idx != 255) begin
      it.addr = idx + 1; it.data = int'(nw[15:8]);
      exp_q.push_back(it);
      shadow[idx + 1] = nw[15:8];
    end
    req = 1'b1; bit_addr = 11'(ba); pattern = pat; mask = msk;
    @(negedge clk);
    req = 1'b0;
    cnt = 1;
    if (inject) begin
      @(negedge clk); cnt++;
      req = 1'b1; bit_addr = 11'(100 * 8); pattern = 8'hFF; mask = 8'hFF;
      @(negedge clk); cnt++;
      req = 1'b0;
    end
    while (!done && cnt < 20) begin
      @(negedge clk); cnt++;
    end
    want = (idx == 255) ? 4 : 6;
    check(cnt == want, (idx == 255) ? "R6" : "R2", "cycles to done", cnt, want);
    @(negedge clk);
    check(done == 1'b0, "R8", "done single cycle", int'(done), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "R2", "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'((i * 37) ^ 8'h5A);
      shadow[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R8", "busy after reset", int'(busy), 0);
    check(done == 1'b0, "R8", "done after reset", int'(done), 0);
    check((mem_rd_en | mem_wr_en) == 1'b0, "R8", "strobes after reset",
          int'({mem_rd_en, mem_wr_en}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5: clear both bytes, set a straddling six-bit field, then clear it
    do_write(456, 8'h00, 8'hFF, "R5", 1'b0);
    do_write(464, 8'h00, 8'hFF, "R5", 1'b0);
    do_write(462, 8'd63, 8'h3F, "R5", 1'b0);
    check(mem[57] == 8'hC0, "R5", "byte 57 after set", int'(mem[57]), 8'hC0);
    check(mem[58] == 8'h0F, "R5", "byte 58 after set", int'(mem[58]), 8'h0F);
    do_write(462, 8'd0, 8'h3F, "R5", 1'b0);
    check(mem[57] == 8'h00, "R5", "byte 57 after clear", int'(mem[57]), 0);
    check(mem[58] == 8'h00, "R5", "byte 58 after clear", int'(mem[58]), 0);

    // R9: mask widths 1..8 at every shift
    for (int w = 1; w <= 8; w++) begin
      for (int s = 0; s < 8; s++) begin
        do_write((w * 16 + 3) * 8 + s, 8'((w * 29 + s * 71) ^ 8'hA5),
                 8'((1 << w) - 1), "R9", 1'b0);
      end
    end

    // R4: stray pattern bits above the mask
    do_write(30 * 8 + 6, 8'hFF, 8'h07, "R4", 1'b0);
    check(mem[31] == shadow[31], "R4", "neighbour byte 31", int'(mem[31]), int'(shadow[31]));

    // R1: bottom of the file
    do_write(0, 8'h96, 8'hFF, "R1", 1'b0);
    do_write(3, 8'h0B, 8'h1F, "R1", 1'b0);

    // R6: field in the last byte, upper bits dropped
    do_write(2045, 8'hAB, 8'hFF, "R6", 1'b0);
    check(mem[0] == shadow[0], "R6", "byte 0 untouched by wrap", int'(mem[0]), int'(shadow[0]));
    do_write(2040, 8'h3C, 8'hF0, "R6", 1'b0);
    // byte 254 still straddles into byte 255
    do_write(254 * 8 + 7, 8'h01, 8'h03, "R2", 1'b0);

    // R7: request raised while busy is ignored
    do_write(200 * 8 + 2, 8'h5C, 8'h7F, "R7", 1'b1);
    check(mem[100] == shadow[100], "R7", "byte 100 untouched", int'(mem[100]), int'(shadow[100]));
    check(busy == 1'b0, "R7", "idle after ignored request", int'(busy), 0);

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R2", "pending writes", exp_q.size(), 0);
    begin
      int bad;
      bad = 0;
      for (int i = 0; i < 256; i++) if (mem[i] !== shadow[i]) bad++;
      check(bad == 0, "R3", "register file mismatches", bad, 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule